// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Router

This block gathers up to 32 level-sensitive interrupt request lines behind a primary vectored interrupt controller. Each source line is registered once. A per-source enable mask gates the registered line. Every enabled source that is not routed directly is ORed onto a single cascade request. That request feeds the primary controller's last input, number 31.

Software changes the enable mask through two write-only strobe registers. Writing a one to the set register turns a source on, and writing a one to the clear register turns it off, so no read-modify-write is needed. A separate direct-route mask lets each of the upper sources (21 through 31 by default) bypass the cascade. Such a source then drives its own primary input of the same number. The masked and raw request vectors can be read over a simple register bus.

Top module: `sec_irq_router`

## Requirements
- R1: After reset the enable mask and the direct-route mask are zero, the cascade request is low, all direct outputs are low, and every register reads zero.
- R2: A write to offset 0x08 sets each enable bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged. A read of offset 0x08 returns the current enable mask. The enable mask changes on no other access.
- R3: A write to offset 0x0C clears each enable bit whose data bit is 1 and leaves the rest unchanged. Writing 0xFFFFFFFF there disables every source.
- R4: Source lines are registered once, so a change on `srcIn` shows one cycle later. A read of offset 0x04 returns the registered lines. A read of offset 0x00 returns the registered lines ANDed with the enable mask, and is zero when nothing enabled is active.
- R5: `cascadeOut` is high exactly when some registered source is active, enabled, and not selected in the direct-route mask. A source selected for direct routing never reaches the cascade, whatever its enable bit.
- R6: `directOut[i]` is the registered source i ANDed with direct-route bit i, independent of the enable mask. Only bits PASS_LO..31 (21..31 by default, mask 0xFFE00000) exist. Lower direct outputs stay 0, and writes to lower direct-route bits are dropped.
- R7: Requests are level-sensitive. An enabled, cascaded source keeps `cascadeOut` high for as long as its line stays high, and `cascadeOut` falls one cycle after the line drops.
- R8: A write to offset 0x20 loads the direct-route mask, and a read of 0x20 returns it. Writes to offsets 0x00, 0x04 or any unmapped offset change no state. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Level-sensitive source request lines |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 6 | Register byte offset |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for `addr` (combinational) |
| cascadeOut | output | 1 | Combined request to primary input 31 |
| directOut | output | 32 | Direct-routed requests to the primary inputs of the same number |

## Verification
Directed sequences cover the following cases:
- Partial set and clear patterns, which show that zero data bits leave their enable bits alone.
- An all-ones clear, which shows that every source can be masked.
- A source held high and then dropped, which shows that the request is a level with one cycle of latency.
- Upper sources that are direct-routed and also enabled, which shows that the direct path ignores the enable mask while the cascade drops those sources.
- Writes of all ones to the read-only and unmapped offsets, and to the lower direct-route bits, which must leave state and outputs unchanged.

A long run then follows. It uses seeded random source vectors and random writes to all offsets, and compares every output and every readable register each cycle against a bench model. This exposes mixes of enabled, masked and direct-routed sources that the directed cases do not reach.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int OFS_STATUS = 'h00;
  localparam int OFS_RAW    = 'h04;
  localparam int OFS_SET    = 'h08;
  localparam int OFS_CLR    = 'h0C;
  localparam int OFS_PASS   = 'h20;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic passWr;
  } sicStrobe_t;
endpackage

// File: rtl/sic_ctrl.sv
module sic_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 6
) (
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NUM_SRC-1:0]     statusVec,
  input  logic [NUM_SRC-1:0]     rawVec,
  input  logic [NUM_SRC-1:0]     enMask,
  input  logic [NUM_SRC-1:0]     passMask,
  output sic_pkg::sicStrobe_t    strobe,
  output logic [NUM_SRC-1:0]     rdData
);
  import sic_pkg::*;

  logic hitStatus, hitRaw, hitSet, hitClr, hitPass;

  always_comb begin
    hitStatus = (addr == ADDR_W'(OFS_STATUS));
    hitRaw    = (addr == ADDR_W'(OFS_RAW));
    hitSet    = (addr == ADDR_W'(OFS_SET));
    hitClr    = (addr == ADDR_W'(OFS_CLR));
    hitPass   = (addr == ADDR_W'(OFS_PASS));
  end

  // Write decode: only three offsets carry side effects
  always_comb begin
    strobe.setEn  = wrEn && hitSet;
    strobe.clrEn  = wrEn && hitClr;
    strobe.passWr = wrEn && hitPass;
  end

  // Read mux: the clear offset and unmapped offsets return zero
  always_comb begin
    rdData = '0;
    if (hitStatus) rdData = statusVec;
    if (hitRaw)    rdData = rawVec;
    if (hitSet)    rdData = enMask;
    if (hitPass)   rdData = passMask;
  end
endmodule

// File: rtl/sic_datapath.sv
module sic_datapath #(
  parameter int NUM_SRC = 32,
  parameter int PASS_LO = 21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcIn,
  input  sic_pkg::sicStrobe_t  strobe,
  input  logic [NUM_SRC-1:0]   wrData,
  output logic [NUM_SRC-1:0]   statusVec,
  output logic [NUM_SRC-1:0]   rawVec,
  output logic [NUM_SRC-1:0]   enMask,
  output logic [NUM_SRC-1:0]   passMask,
  output logic                 cascadeOut,
  output logic [NUM_SRC-1:0]   directOut
);
  logic [NUM_SRC-1:0] srcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcQ <= '0;
    else       srcQ <= srcIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enMask <= '0;
    else if (strobe.setEn)  enMask <= enMask | wrData;
    else if (strobe.clrEn)  enMask <= enMask & ~wrData;
  end

  // Direct-route bits exist only for the upper sources
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pass
    if (i < PASS_LO) begin : g_none
      assign passMask[i] = 1'b0;
    end else begin : g_bit
      logic passQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              passQ <= 1'b0;
        else if (strobe.passWr) passQ <= wrData[i];
      end
      assign passMask[i] = passQ;
    end
  end

  always_comb begin
    rawVec     = srcQ;
    statusVec  = srcQ & enMask;
    cascadeOut = |(srcQ & enMask & ~passMask);
    directOut  = srcQ & passMask;
  end
endmodule

// File: rtl/sec_irq_router.sv
module sec_irq_router #(
  parameter int NUM_SRC = 32,
  parameter int PASS_LO = 21,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               cascadeOut,
  output logic [NUM_SRC-1:0] directOut
);
  sic_pkg::sicStrobe_t strobe;
  logic [NUM_SRC-1:0]  statusVec, rawVec, enMask, passMask;

  sic_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .statusVec(statusVec), .rawVec(rawVec),
    .enMask(enMask), .passMask(passMask), .strobe(strobe), .rdData(rdData)
  );

  sic_datapath #(.NUM_SRC(NUM_SRC), .PASS_LO(PASS_LO)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strobe(strobe), .wrData(wrData),
    .statusVec(statusVec), .rawVec(rawVec), .enMask(enMask),
    .passMask(passMask), .cascadeOut(cascadeOut), .directOut(directOut)
  );
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int NUM_SRC = 32,
  parameter int PASS_LO = 21,
  parameter int ADDR_W  = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_SRC-1:0] wrData,
  input logic [NUM_SRC-1:0] rdData,
  input logic               cascadeOut,
  input logic [NUM_SRC-1:0] directOut,
  input logic [NUM_SRC-1:0] enMask,
  input logic [NUM_SRC-1:0] passMask
);
  import sic_pkg::*;

  logic isSet, isClr, isPass;
  assign isSet  = wrEn && (addr == ADDR_W'(OFS_SET));
  assign isClr  = wrEn && (addr == ADDR_W'(OFS_CLR));
  assign isPass = wrEn && (addr == ADDR_W'(OFS_PASS));

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    isSet |=> ((enMask & $past(wrData)) == $past(wrData)));

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(isSet || isClr) |=> $stable(enMask));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    isClr |=> ((enMask & $past(wrData)) == '0));

  assert_status_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(OFS_STATUS)) |-> ((rdData & ~enMask) == '0));

  assert_cascade_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    cascadeOut |-> (|($past(srcIn) & enMask & ~passMask)));

  assert_direct_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    (directOut & ~($past(srcIn) & passMask)) == '0);

  assert_pass_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !isPass |=> $stable(passMask));
endmodule

bind sec_irq_router sic_checker #(.NUM_SRC(NUM_SRC), .PASS_LO(PASS_LO), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .cascadeOut(cascadeOut),
  .directOut(directOut), .enMask(enMask), .passMask(passMask)
);

// File: tb/sec_irq_router_bench.sv
`timescale 1ns/100ps
module sec_irq_router_bench;
  localparam logic [31:0] PASS_CAP = 32'hFFE0_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] srcIn;
  logic        wrEn;
  logic [5:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        cascadeOut;
  logic [31:0] directOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] mSrc, mEn, mPass;

  always #4 clk = ~clk;

  sec_irq_router u_sec_irq_router (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cascadeOut(cascadeOut),
    .directOut(directOut)
  );

  // Reference model, updated from the requirements
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSrc <= '0; mEn <= '0; mPass <= '0;
    end else begin
      mSrc <= srcIn;
      if (wrEn && addr == 6'h08) mEn <= mEn | wrData;
      if (wrEn && addr == 6'h0C) mEn <= mEn & ~wrData;
      if (wrEn && addr == 6'h20) mPass <= wrData & PASS_CAP;
    end
  end

  function automatic logic expCascade();
    return |(mSrc & mEn & ~mPass);
  endfunction

  task automatic chk(string req, string ctx, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual %h expected %h", req, ctx, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    addr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic checkAll(string ctx);
    logic [31:0] v;
    chk("R5", ctx, {31'd0, cascadeOut}, {31'd0, expCascade()});
    chk("R6", ctx, directOut, mSrc & mPass);
    rd(6'h00, v); chk("R4", ctx, v, mSrc & mEn);
    rd(6'h04, v); chk("R4", ctx, v, mSrc);
    rd(6'h08, v); chk("R2", ctx, v, mEn);
    rd(6'h20, v); chk("R8", ctx, v, mPass);
    rd(6'h10, v); chk("R8", ctx, v, 32'd0);
    rd(6'h0C, v); chk("R8", ctx, v, 32'd0);
  endtask

  task automatic wrReg(logic [5:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setSrc(logic [31:0] v);
    srcIn = v;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; srcIn = '0; wrEn = 1'b0; addr = '0; wrData = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    // R2: set, zero bits untouched
    wrReg(6'h08, 32'h0000_00F0);
    setSrc(32'h0000_0010);
    checkAll("R2 set partial");
    wrReg(6'h08, 32'h0000_0001);
    chk("R2", "zero bits keep", mEn, 32'h0000_00F1);
    checkAll("R2 set second");

    // R3: clear partial then all
    wrReg(6'h0C, 32'h0000_0030);
    checkAll("R3 clear partial");
    wrReg(6'h0C, 32'hFFFF_FFFF);
    checkAll("R3 clear all");
    chk("R3", "all masked cascade", {31'd0, cascadeOut}, 32'd0);

    // R7: level behaviour with one-cycle latency
    wrReg(6'h08, 32'h0000_0008);
    srcIn = 32'h0000_0008;
    chk("R7", "before latch", {31'd0, cascadeOut}, 32'd0);
    @(negedge clk);
    chk("R7", "raised", {31'd0, cascadeOut}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R7", "held", {31'd0, cascadeOut}, 32'd1);
    srcIn = 32'h0;
    chk("R7", "same cycle drop", {31'd0, cascadeOut}, 32'd1);
    @(negedge clk);
    chk("R7", "dropped", {31'd0, cascadeOut}, 32'd0);

    // R6/R5: direct routing ignores enable, leaves cascade
    wrReg(6'h20, 32'hFFFF_FFFF);
    checkAll("R6 low pass bits dropped");
    setSrc(32'h8020_0008);
    checkAll("R6 direct without enable");
    chk("R6", "direct vector", directOut, 32'h8020_0000);
    wrReg(6'h08, 32'h8000_0000);
    wrReg(6'h0C, 32'h0000_0008);
    checkAll("R5 passed source excluded");
    chk("R5", "only passed enabled", {31'd0, cascadeOut}, 32'd0);
    wrReg(6'h20, 32'h0);
    checkAll("R5 pass removed");
    chk("R5", "back in cascade", {31'd0, cascadeOut}, 32'd1);

    // R8: read-only and unmapped offsets ignore writes
    wrReg(6'h00, 32'hFFFF_FFFF);
    wrReg(6'h04, 32'hFFFF_FFFF);
    wrReg(6'h10, 32'hFFFF_FFFF);
    wrReg(6'h3C, 32'hFFFF_FFFF);
    checkAll("R8 ignored writes");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int pick;
      srcIn = $urandom();
      pick = $urandom_range(0, 9);
      wrData = $urandom();
      wrEn = (pick < 6);
      case (pick % 6)
        0, 1: addr = 6'h08;
        2, 3: addr = 6'h0C;
        4:    addr = 6'h20;
        default: addr = 6'h10;
      endcase
      @(negedge clk);
      wrEn = 1'b0;
      checkAll("random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule